// File: doc/BRIEF.md
# Interlocked Parallel Byte Link Transmitter

This block takes bytes from a host and sends them one at a time over an 8-bit parallel link. The link uses two handshake wires: an active-low strobe that the block drives and a busy line that the peer drives. A third output marks each byte as a command or as ordinary data. The host writes bytes through one of two write strobes. One strobe marks the byte as a command and the other marks it as data. Each write places a byte and a one-bit tag into a 16-entry queue.

The block drains the queue with no further action from the host. For each entry it waits until the peer's busy line is low. It then puts the byte and the command/data level on the wires, lowers the strobe one clock later, and keeps everything steady until the peer raises busy. Then it releases the strobe and moves to the next entry. No wait has a time limit, so a silent peer stalls the link indefinitely and nothing is lost. A command byte uses its top bit to select its meaning: 0 means a run-length count in the low seven bits and 1 means a channel address. The block sends such bytes unaltered.

Top module: `plink_tx`

## Requirements
- R1: The queue holds 16 entries. Every accepted entry is sent exactly once, in write order, with no host action beyond the write.
- R2: A write through the command strobe stores tag 0, and link_cd is low while that byte is on the wires. A write through the data strobe stores tag 1, and link_cd is high while that byte is on the wires.
- R3: If both write strobes are high in the same cycle, exactly one entry is stored, and it is tagged as a command (tag 0).
- R4: A new byte and its link_cd level appear on one rising clock edge, and link_stb_n falls on the following edge. link_data and link_cd stay unchanged for as long as link_stb_n is low.
- R5: link_busy passes through a two-flop synchronizer. link_stb_n never falls while the synchronized busy is high. It rises on the third rising clock edge after link_busy goes high.
- R6: All 8 bits of each byte reach link_data unchanged, for all 256 values. This includes command bytes of both forms: bit 7 = 0 (run-length count) and bit 7 = 1 (channel address).
- R7: No wait times out. link_stb_n stays low for as long as the peer keeps busy low. No byte is started while the peer holds busy high.
- R8: fifo_count updates on the clock edge after a write or a send. fifo_full is high exactly when the count is 16, and fifo_empty is high exactly when the count is 0.
- R9: A write while the queue is full is dropped and sets ovf_flag. ovf_flag stays set until reset.
- R10: During and after reset: link_stb_n = 1, link_cd = 1, link_data = 0, fifo_count = 0, fifo_empty = 1, fifo_full = 0 and ovf_flag = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe that queues wr_byte with tag 0 (command) |
| dat_wr | input | 1 | Write strobe that queues wr_byte with tag 1 (data) |
| wr_byte | input | 8 | Byte to be queued |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_count | output | 5 | Number of queued entries |
| ovf_flag | output | 1 | Sticky flag: a write was dropped because the queue was full |
| link_data | output | 8 | Byte driven to the peer |
| link_cd | output | 1 | Command/data line: low for a command byte, high for a data byte |
| link_stb_n | output | 1 | Active-low strobe to the peer |
| link_busy | input | 1 | Peer busy line, asynchronous to clk |

## Verification
The bench sends every byte value. It mixes the command strobe, the data strobe and both strobes at once, and it varies how long the peer takes to raise and to drop busy. A design that moved the strobe on the same edge as the data, or changed the byte while the strobe was low, would show a changed byte at the strobe edge. A design with a missing or extra synchronizer stage would release the strobe one clock early or late. The bench fills the queue while the peer holds busy high, then writes a seventeenth byte. A design that accepted that write, or cleared the overflow flag on its own, would send 17 bytes or show the flag low after the queue drains. The bench also holds busy low for hundreds of cycles with the strobe low, so any hidden timeout would release the strobe early or change the byte.

// File: rtl/plink_pkg.sv
package plink_pkg;

    localparam int LINK_W = 8;

    localparam logic TAG_CMD = 1'b0;
    localparam logic TAG_DAT = 1'b1;

    typedef struct packed {
        logic              tag;
        logic [LINK_W-1:0] val;
    } q_entry_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SETUP = 2'd1,
        HS_WAIT  = 2'd2
    } hs_state_t;

    // Command strobe takes priority when both strobes are high.
    function automatic q_entry_t make_entry(input logic cmd, input logic [LINK_W-1:0] b);
        q_entry_t e;
        e.tag = cmd ? TAG_CMD : TAG_DAT;
        e.val = b;
        return e;
    endfunction

endpackage

// File: rtl/plink_sync.sv
module plink_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= RST_VAL;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/plink_fifo.sv
module plink_fifo
    import plink_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  q_entry_t      push_ent,
    input  logic          pop,
    output q_entry_t      head,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          ovf
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    q_entry_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic            do_wr, do_rd;

    assign do_wr = push && (count != FULL_CNT);
    assign do_rd = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && (count == FULL_CNT)) ovf <= 1'b1;
        end
    end

    assign head  = mem[rp];
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
endmodule

// File: rtl/plink_hs.sv
module plink_hs
    import plink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ent_valid,
    input  q_entry_t          ent,
    input  logic              busy_s,
    output logic              take,
    output logic [LINK_W-1:0] data_o,
    output logic              cd_o,
    output logic              stb_n_o
);
    hs_state_t state;

    assign take = (state == HS_IDLE) && ent_valid && !busy_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HS_IDLE;
            data_o  <= '0;
            cd_o    <= 1'b1;
            stb_n_o <= 1'b1;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (take) begin
                        data_o <= ent.val;
                        cd_o   <= ent.tag;
                        state  <= HS_SETUP;
                    end
                end
                HS_SETUP: begin
                    stb_n_o <= 1'b0;
                    state   <= HS_WAIT;
                end
                HS_WAIT: begin
                    if (busy_s) begin
                        stb_n_o <= 1'b1;
                        state   <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/plink_tx.sv
module plink_tx
    import plink_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [LINK_W-1:0] wr_byte,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic [CW-1:0]     fifo_count,
    output logic              ovf_flag,
    output logic [LINK_W-1:0] link_data,
    output logic              link_cd,
    output logic              link_stb_n,
    input  logic              link_busy
);
    q_entry_t in_ent, head;
    logic     any_wr, take, busy_s;

    assign any_wr = cmd_wr | dat_wr;
    assign in_ent = make_entry(cmd_wr, wr_byte);

    plink_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (link_busy),
        .d_out(busy_s)
    );

    plink_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (any_wr),
        .push_ent(in_ent),
        .pop     (take),
        .head    (head),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .count   (fifo_count),
        .ovf     (ovf_flag)
    );

    plink_hs u_hs (
        .clk      (clk),
        .rst      (rst),
        .ent_valid(!fifo_empty),
        .ent      (head),
        .busy_s   (busy_s),
        .take     (take),
        .data_o   (link_data),
        .cd_o     (link_cd),
        .stb_n_o  (link_stb_n)
    );
endmodule

// File: rtl/plink_tx_chk.sv
module plink_tx_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [7:0]    link_data,
    input logic          link_cd,
    input logic          link_stb_n,
    input logic          busy_s,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          ovf_flag
);
    // R4
    stb_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_stb_n) |-> ($stable(link_data) && $stable(link_cd)));

    // R4
    stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!link_stb_n && !$fell(link_stb_n)) |-> ($stable(link_data) && $stable(link_cd)));

    // R5
    stb_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!link_stb_n && busy_s) |=> link_stb_n);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(fifo_count) <= DEPTH) &&
        ((int'(fifo_count) == int'($past(fifo_count))) ||
         (int'(fifo_count) == int'($past(fifo_count)) + 1) ||
         (int'(fifo_count) + 1 == int'($past(fifo_count)))));

    // R8
    full_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);
endmodule

bind plink_tx plink_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .link_data (link_data),
    .link_cd   (link_cd),
    .link_stb_n(link_stb_n),
    .busy_s    (busy_s),
    .fifo_count(fifo_count),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .ovf_flag  (ovf_flag)
);

// File: tb/tb_plink_tx.sv
module tb_plink_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_wr = 1'b0, dat_wr = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       fifo_full, fifo_empty, ovf_flag, link_cd, link_stb_n;
    logic [4:0] fifo_count;
    logic [7:0] link_data;
    logic       link_busy = 1'b1;

    int   n_chk = 0, n_fail = 0, rx_n = 0;
    bit   hold = 1'b1, mute = 1'b0, done = 1'b0, mon_on = 1'b0;
    logic [8:0] exp_q [$];

    always #2 clk = ~clk;

    plink_tx dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .wr_byte(wr_byte),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
        .ovf_flag(ovf_flag), .link_data(link_data), .link_cd(link_cd),
        .link_stb_n(link_stb_n), .link_busy(link_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // kind: 0 command, 1 data, 2 both strobes
    task automatic wr(input int kind, input logic [7:0] b, input bit expect_ok);
        @(negedge clk);
        cmd_wr  = (kind != 1);
        dat_wr  = (kind != 0);
        wr_byte = b;
        if (expect_ok) exp_q.push_back({(kind == 1), b});
        @(negedge clk);
        cmd_wr = 1'b0;
        dat_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && fifo_empty && link_stb_n && !link_busy) return;
        end
        chk(1'b0, "R1 drain", exp_q.size(), 0);
    endtask

    // Peer model
    initial begin
        forever begin
            @(negedge clk);
            if (hold) begin
                link_busy = 1'b1;
                continue;
            end
            if (link_busy) link_busy = 1'b0;
            else if (!mute && !rst && link_stb_n == 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected byte", link_data, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(link_data == e[7:0], "R6 byte", link_data, e[7:0]);
                    chk(link_cd == e[8], "R2 tag", link_cd, e[8]);
                end
                repeat (rx_n % 4) @(negedge clk);
                link_busy = 1'b1;
                repeat (2) @(negedge clk);
                chk(link_stb_n == 1'b0, "R5 early release", link_stb_n, 0);
                @(negedge clk);
                chk(link_stb_n == 1'b1, "R5 release", link_stb_n, 1);
                repeat ((rx_n / 4) % 3) @(negedge clk);
                link_busy = 1'b0;
                rx_n++;
            end
        end
    end

    // Strobe/data stability monitor
    initial begin
        logic       p_stb;
        logic [7:0] p_dat;
        logic       p_cd;
        p_stb = 1'b1; p_dat = 8'h00; p_cd = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (!link_stb_n) begin
                    chk(link_data == p_dat, "R4 data at strobe", link_data, p_dat);
                    chk(link_cd == p_cd, "R4 cd at strobe", link_cd, p_cd);
                end
                if (!link_stb_n && !p_stb) chk(1'b1, "R4", 0, 0);
            end
            p_stb = link_stb_n; p_dat = link_data; p_cd = link_cd;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(link_stb_n == 1'b1, "R10 strobe", link_stb_n, 1);
        chk(link_cd == 1'b1, "R10 cd", link_cd, 1);
        chk(link_data == 8'h00, "R10 data", link_data, 0);
        chk(fifo_count == 5'd0 && fifo_empty && !fifo_full, "R10 queue", fifo_count, 0);
        chk(ovf_flag == 1'b0, "R10 overflow", ovf_flag, 0);
        rst = 1'b0;
        mon_on = 1'b1;

        // Fill with peer holding busy high: R7 no byte starts, R8 counts
        for (int i = 0; i < 16; i++) begin
            wr(i % 2, 8'hA0 + 8'(i), 1'b1);
            chk(fifo_count == 5'(i + 1), "R8 count", fifo_count, i + 1);
            chk(fifo_full == (i == 15), "R8 full", fifo_full, (i == 15));
            chk(!fifo_empty, "R8 empty", fifo_empty, 0);
        end
        chk(link_stb_n == 1'b1, "R7 held busy", link_stb_n, 1);
        wr(1, 8'h5A, 1'b0);
        chk(fifo_count == 5'd16, "R9 dropped write", fifo_count, 16);
        chk(ovf_flag == 1'b1, "R9 overflow set", ovf_flag, 1);
        hold = 1'b0;
        wait_idle();
        chk(rx_n == 16, "R1 sixteen sent", rx_n, 16);
        chk(ovf_flag == 1'b1, "R9 sticky", ovf_flag, 1);
        chk(fifo_empty && fifo_count == 5'd0, "R8 empty after drain", fifo_count, 0);

        // Sweep all byte values, three write styles (R3 for kind 2)
        for (int v = 0; v < 256; v++) begin
            while (fifo_full) @(negedge clk);
            wr(v % 3, 8'(v), 1'b1);
        end
        wait_idle();
        chk(rx_n == 16 + 256, "R1 sweep count", rx_n, 16 + 256);
        chk(!fifo_full && fifo_empty, "R8 idle flags", fifo_count, 0);

        // Stall with strobe low: R7 no timeout
        mute = 1'b1;
        wr(1, 8'h3C, 1'b1);
        for (int i = 0; i < 50 && link_stb_n; i++) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(link_stb_n == 1'b0, "R7 strobe stays low", link_stb_n, 0);
        chk(link_data == 8'h3C, "R7 data held", link_data, 8'h3C);
        chk(link_cd == 1'b1, "R7 cd held", link_cd, 1);
        mute = 1'b0;
        wait_idle();
        chk(rx_n == 16 + 256 + 1, "R1 stalled byte sent", rx_n, 273);
        finish_test();
    end
endmodule